// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block turns one upstream command into the ordered list of frame operations that an I2C master carries out. It sits above a bit-level shift engine and never touches the SCL or SDA waveform. A command names a slave address, which may be 7-bit or 10-bit, a direction and a byte count. The sequencer then asks the engine, one step at a time, for START, the address bytes, a repeated START where needed, the data bytes and STOP. It checks the slave's acknowledge after every byte it transmits. On reads it tells the engine whether to answer each byte with ACK or NACK.

Write data comes in and read data goes out through valid/ready handshakes. When STOP has completed, the sequencer reports the end of the transaction with a one-cycle pulse and an error flag. If the slave fails to acknowledge an address byte or a written byte, the transaction is cut short with STOP and the error flag is raised.

Engine operation codes on `eng_op`: 1 = START, 2 = repeated START, 3 = STOP, 4 = transmit byte, 5 = receive byte.

Top module: `i2c_txn_seq`

## Requirements
- R1: After reset `cmd_ready` is 1 and `eng_req_valid`, `wr_ready`, `rd_valid` and `txn_done` are 0. A command is taken when `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` then stays 0 until the transaction has finished.
- R2: Every transaction opens with a START request (op 1) and closes with a STOP request (op 3). One cycle after the STOP completes, `txn_done` is 1 for exactly one cycle.
- R3: With a 7-bit address, the first transmitted byte is `{cmd_addr[6:0], rw}`. The bit `rw` is 0 for a write and 1 for a read.
- R4: A 10-bit write transmits `{5'b11110, cmd_addr[9:8], 1'b0}` and then `cmd_addr[7:0]`, followed by the data bytes.
- R5: A 10-bit read transmits `{5'b11110, cmd_addr[9:8], 1'b0}` and then `cmd_addr[7:0]`. It then issues a repeated START (op 2), transmits `{5'b11110, cmd_addr[9:8], 1'b1}`, and only after that starts receiving.
- R6: On a write, each of the `cmd_len` data bytes is taken through `wr_valid`/`wr_ready` and sent as a transmit request (op 4), in the order received. `wr_ready` is 1 only while the sequencer waits for a byte.
- R7: On a read, `cmd_len` receive requests (op 5) are issued. `eng_nack` is 0 on every one except the last, where it is 1. Each received byte is held on `rd_data` with `rd_valid` at 1 until `rd_ready` takes it, and bytes come out in the order they were received.
- R8: If `eng_ack_n` is 1 when a transmit request completes, no further byte or repeated-START request follows. The next request is STOP, and `txn_err` is 1 while `txn_done` pulses.
- R9: A `cmd_len` of 0 runs the complete address phase and then goes straight to STOP, without moving any data.
- R10: `eng_req_valid` stays at 1 with `eng_op`, `eng_tx_byte` and `eng_nack` unchanged until `eng_req_ready` is 1. No new request appears until `eng_done` has ended the previous one.
- R11: A transaction in which every transmitted byte is acknowledged ends with `txn_err` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command accepted |
| cmd_addr | input | 10 | Slave address (bits 6:0 used in 7-bit mode) |
| cmd_ten | input | 1 | 1 selects 10-bit addressing |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_len | input | LEN_W | Number of data bytes |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte accepted |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| eng_req_valid | output | 1 | Request to the shift engine |
| eng_req_ready | input | 1 | Engine accepts the request |
| eng_op | output | 3 | Requested operation (codes above) |
| eng_tx_byte | output | 8 | Byte to transmit (op 4) |
| eng_nack | output | 1 | Acknowledge to drive after a received byte: 1 = NACK |
| eng_done | input | 1 | Engine finished the accepted request |
| eng_ack_n | input | 1 | Slave acknowledge after a transmit: 1 = not acknowledged |
| eng_rx_byte | input | 8 | Received byte, valid with eng_done |
| txn_done | output | 1 | One-cycle pulse after STOP |
| txn_err | output | 1 | Transaction was aborted by a missing ACK |

## Verification
The bench builds the sequencer with `LEN_W = 4`, which makes the largest byte count (15) reachable quickly. Directed runs cover the full-length write and read, zero-length transfers in both address modes, and aborts at every position where a missing ACK can occur: the first address byte, the second address byte, the re-sent read address and a mid-stream data byte. Random commands on top of these mix address mode, direction, length and the point of the NACK. A behavioural engine adds random accept and completion delays, and the consumers add random backpressure on the write and read handshakes.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_START  = 3'd1,
    OP_RSTART = 3'd2,
    OP_STOP   = 3'd3,
    OP_TX     = 3'd4,
    OP_RX     = 3'd5
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_A1, S_A2, S_RS, S_A3,
    S_WD, S_TXD, S_RXD, S_PUSH, S_STOP
  } st_e;

  function automatic op_e op_of(st_e s);
    case (s)
      S_START:                return OP_START;
      S_RS:                   return OP_RSTART;
      S_STOP:                 return OP_STOP;
      S_A1, S_A2, S_A3, S_TXD: return OP_TX;
      S_RXD:                  return OP_RX;
      default:                return OP_NONE;
    endcase
  endfunction

  function automatic logic uses_engine(st_e s);
    return !(s == S_IDLE || s == S_WD || s == S_PUSH);
  endfunction

endpackage

// File: rtl/i2cs_addr_fmt.sv
`timescale 1ns/1ps
module i2cs_addr_fmt #(
  parameter logic [4:0] TEN_PFX = 5'b11110
) (
  input  logic [9:0] addr,
  input  logic       ten,
  input  logic       rw,
  output logic [7:0] first_b,
  output logic [7:0] second_b
);
  // Header byte: prefix plus the two top bits in 10-bit mode, else 7 bits.
  always_comb begin
    if (ten) first_b = {TEN_PFX, addr[9:8], rw};
    else     first_b = {addr[6:0], rw};
    second_b = addr[7:0];
  end
endmodule

// File: rtl/i2cs_byte_cnt.sv
`timescale 1ns/1ps
module i2cs_byte_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero,
  output logic         one
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - ONE;
  end

  assign zero = (cnt_q == '0);
  assign one  = (cnt_q == ONE);

  AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    dec |-> cnt_q != '0); // R6
endmodule

// File: rtl/i2cs_ctrl.sv
`timescale 1ns/1ps
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter logic [4:0] TEN_PFX = 5'b11110
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [9:0] cmd_addr,
  input  logic       cmd_ten,
  input  logic       cmd_read,
  output logic       cmd_ready,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output logic       wr_ready,
  input  logic       rd_ready,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       eng_req_valid,
  input  logic       eng_req_ready,
  output logic [2:0] eng_op,
  output logic [7:0] eng_tx_byte,
  output logic       eng_nack,
  input  logic       eng_done,
  input  logic       eng_ack_n,
  input  logic [7:0] eng_rx_byte,
  output logic       txn_done,
  output logic       txn_err,
  input  logic       cnt_zero,
  input  logic       cnt_one,
  output logic       cnt_load,
  output logic       cnt_dec,
  input  logic [7:0] first_b,
  input  logic [7:0] second_b,
  output logic [9:0] addr_o,
  output logic       ten_o,
  output logic       rw_o
);
  st_e        state_q, state_d;
  logic [9:0] addr_q;
  logic       ten_q, rd_q;
  logic       req_vld_q, wait_q;
  logic [2:0] op_q;
  logic [7:0] byte_q, byte_d, rx_q;
  logic       nack_q, done_q, err_q;
  logic       fin, abort, launch;
  st_e        data_nx;

  assign fin     = wait_q & eng_done;
  assign data_nx = cnt_zero ? S_STOP : (rd_q ? S_RXD : S_WD);

  // Next state
  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    abort    = 1'b0;
    case (state_q)
      S_IDLE:  if (cmd_valid) begin state_d = S_START; cnt_load = 1'b1; end
      S_START: if (fin) state_d = S_A1;
      S_A1: if (fin) begin
        if (eng_ack_n)  begin state_d = S_STOP; abort = 1'b1; end
        else if (ten_q) state_d = S_A2;
        else            state_d = data_nx;
      end
      S_A2: if (fin) begin
        if (eng_ack_n) begin state_d = S_STOP; abort = 1'b1; end
        else if (rd_q) state_d = S_RS;
        else           state_d = data_nx;
      end
      S_RS: if (fin) state_d = S_A3;
      S_A3: if (fin) begin
        if (eng_ack_n) begin state_d = S_STOP; abort = 1'b1; end
        else           state_d = data_nx;
      end
      S_WD: if (wr_valid) state_d = S_TXD;
      S_TXD: if (fin) begin
        if (eng_ack_n) begin state_d = S_STOP; abort = 1'b1; end
        else begin
          cnt_dec = 1'b1;
          state_d = cnt_one ? S_STOP : S_WD;
        end
      end
      S_RXD: if (fin) begin cnt_dec = 1'b1; state_d = S_PUSH; end
      S_PUSH: if (rd_ready) state_d = cnt_zero ? S_STOP : S_RXD;
      S_STOP: if (fin) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // Header direction: re-sent 10-bit header follows the repeated START
  assign rw_o   = ten_q ? (state_q == S_RS) : rd_q;
  assign addr_o = addr_q;
  assign ten_o  = ten_q;

  assign launch = (state_d != state_q) && uses_engine(state_d);

  always_comb begin
    case (state_d)
      S_A1, S_A3: byte_d = first_b;
      S_A2:       byte_d = second_b;
      S_TXD:      byte_d = wr_data;
      default:    byte_d = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      addr_q    <= '0;
      ten_q     <= 1'b0;
      rd_q      <= 1'b0;
      req_vld_q <= 1'b0;
      wait_q    <= 1'b0;
      op_q      <= OP_NONE;
      byte_q    <= '0;
      nack_q    <= 1'b0;
      rx_q      <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      if (state_q == S_IDLE && cmd_valid) begin
        addr_q <= cmd_addr;
        ten_q  <= cmd_ten;
        rd_q   <= cmd_read;
        err_q  <= 1'b0;
      end
      if (abort) err_q <= 1'b1;
      if (fin) wait_q <= 1'b0;
      if (req_vld_q && eng_req_ready) begin
        req_vld_q <= 1'b0;
        wait_q    <= 1'b1;
      end
      if (launch) begin
        req_vld_q <= 1'b1;
        op_q      <= op_of(state_d);
        byte_q    <= byte_d;
        nack_q    <= (state_d == S_RXD) && cnt_one;
      end
      if (state_q == S_RXD && fin)  rx_q   <= eng_rx_byte;
      if (state_q == S_STOP && fin) done_q <= 1'b1;
    end
  end

  assign cmd_ready     = (state_q == S_IDLE);
  assign wr_ready      = (state_q == S_WD);
  assign rd_valid      = (state_q == S_PUSH);
  assign rd_data       = rx_q;
  assign eng_req_valid = req_vld_q;
  assign eng_op        = op_q;
  assign eng_tx_byte   = byte_q;
  assign eng_nack      = nack_q;
  assign txn_done      = done_q;
  assign txn_err       = err_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req_vld_q && !eng_req_ready |=> req_vld_q && $stable(op_q) && $stable(byte_q) && $stable(nack_q)); // R10
  AST_RX_NACK_LAST: assert property (@(posedge clk) disable iff (rst)
    req_vld_q && op_q == OP_RX |-> nack_q == cnt_one); // R7
  AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(op_q) == OP_STOP); // R2
  AST_WR_ONLY_IDLE_ENGINE: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> !req_vld_q && !wait_q); // R6
  AST_TEN_READ_HEADER: assert property (@(posedge clk) disable iff (rst)
    req_vld_q && state_q == S_A3 |-> byte_q[0] && byte_q[7:3] == TEN_PFX); // R5
  AST_ERR_GOES_STOP: assert property (@(posedge clk) disable iff (rst)
    err_q && state_q != S_IDLE |-> state_q == S_STOP); // R8
endmodule

// File: rtl/i2c_txn_seq.sv
`timescale 1ns/1ps
module i2c_txn_seq #(
  parameter int         LEN_W   = 8,
  parameter logic [4:0] TEN_PFX = 5'b11110
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [9:0]       cmd_addr,
  input  logic             cmd_ten,
  input  logic             cmd_read,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             eng_req_valid,
  input  logic             eng_req_ready,
  output logic [2:0]       eng_op,
  output logic [7:0]       eng_tx_byte,
  output logic             eng_nack,
  input  logic             eng_done,
  input  logic             eng_ack_n,
  input  logic [7:0]       eng_rx_byte,
  output logic             txn_done,
  output logic             txn_err
);
  logic       cnt_zero, cnt_one, cnt_load, cnt_dec;
  logic [7:0] first_b, second_b;
  logic [9:0] addr_l;
  logic       ten_l, rw_l;

  i2cs_byte_cnt #(.W(LEN_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cmd_len),
    .dec(cnt_dec), .zero(cnt_zero), .one(cnt_one)
  );

  i2cs_addr_fmt #(.TEN_PFX(TEN_PFX)) u_fmt (
    .addr(addr_l), .ten(ten_l), .rw(rw_l),
    .first_b(first_b), .second_b(second_b)
  );

  i2cs_ctrl #(.TEN_PFX(TEN_PFX)) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_ten(cmd_ten),
    .cmd_read(cmd_read), .cmd_ready(cmd_ready),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .eng_req_valid(eng_req_valid), .eng_req_ready(eng_req_ready),
    .eng_op(eng_op), .eng_tx_byte(eng_tx_byte), .eng_nack(eng_nack),
    .eng_done(eng_done), .eng_ack_n(eng_ack_n), .eng_rx_byte(eng_rx_byte),
    .txn_done(txn_done), .txn_err(txn_err),
    .cnt_zero(cnt_zero), .cnt_one(cnt_one),
    .cnt_load(cnt_load), .cnt_dec(cnt_dec),
    .first_b(first_b), .second_b(second_b),
    .addr_o(addr_l), .ten_o(ten_l), .rw_o(rw_l)
  );
endmodule

// File: tb/test_i2c_txn_seq.sv
`timescale 1ns/1ps
module test_i2c_txn_seq;
  localparam int LW = 4;
  localparam logic [2:0] K_START = 3'd1, K_RS = 3'd2, K_STOP = 3'd3,
                         K_TX = 3'd4, K_RX = 3'd5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0, cmd_ready;
  logic [9:0]    cmd_addr = '0;
  logic          cmd_ten = 1'b0, cmd_read = 1'b0;
  logic [LW-1:0] cmd_len = '0;
  logic          wr_valid = 1'b0, wr_ready;
  logic [7:0]    wr_data = '0;
  logic          rd_valid, rd_ready = 1'b0;
  logic [7:0]    rd_data;
  logic          eng_req_valid, eng_req_ready = 1'b0;
  logic [2:0]    eng_op;
  logic [7:0]    eng_tx_byte;
  logic          eng_nack;
  logic          eng_done = 1'b0, eng_ack_n = 1'b0;
  logic [7:0]    eng_rx_byte = '0;
  logic          txn_done, txn_err;

  i2c_txn_seq #(.LEN_W(LW)) i_i2c_txn_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_ten(cmd_ten), .cmd_read(cmd_read), .cmd_len(cmd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .eng_req_valid(eng_req_valid), .eng_req_ready(eng_req_ready), .eng_op(eng_op),
    .eng_tx_byte(eng_tx_byte), .eng_nack(eng_nack), .eng_done(eng_done),
    .eng_ack_n(eng_ack_n), .eng_rx_byte(eng_rx_byte),
    .txn_done(txn_done), .txn_err(txn_err)
  );

  int n_chk = 0, n_fail = 0;
  int nack_at = 0, tx_k = 0, rx_k = 0;
  logic [2:0] log_op [0:31];
  logic [7:0] log_b  [0:31];
  logic       log_nk [0:31];
  int         log_n = 0;
  logic [2:0] e_op [0:31];
  logic [7:0] e_b  [0:31];
  logic       e_nk [0:31];
  int         e_n = 0;
  logic [7:0] gen_rx [0:31];
  logic [7:0] rd_got [0:31];
  logic [7:0] wdat   [0:31];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ex_add(input logic [2:0] o, input logic [7:0] b, input logic n);
    e_op[e_n] = o; e_b[e_n] = b; e_nk[e_n] = n; e_n++;
  endtask

  // Behavioural shift engine with random accept and completion delays
  initial begin
    forever begin
      @(negedge clk);
      if (eng_req_valid && !rst) begin
        logic [2:0] o;
        logic [7:0] b;
        logic       nk;
        o = eng_op; b = eng_tx_byte; nk = eng_nack;
        repeat ($urandom % 3) @(negedge clk);
        chk(eng_req_valid && eng_op == o && eng_tx_byte == b && eng_nack == nk,
            "R10", "request held until accepted", int'(eng_op), int'(o));
        eng_req_ready = 1'b1;
        if (log_n < 32) begin
          log_op[log_n] = o; log_b[log_n] = b; log_nk[log_n] = nk;
        end
        log_n++;
        @(negedge clk);
        eng_req_ready = 1'b0;
        repeat ($urandom % 3) begin
          @(negedge clk);
          chk(!eng_req_valid, "R10", "no request while one is outstanding", int'(eng_req_valid), 0);
        end
        eng_ack_n = 1'b0;
        if (o == K_TX) begin tx_k++; eng_ack_n = (tx_k == nack_at); end
        if (o == K_RX) begin
          eng_rx_byte = 8'($urandom);
          if (rx_k < 32) gen_rx[rx_k] = eng_rx_byte;
          rx_k++;
        end
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
      end
    end
  end

  task automatic run(input logic [9:0] a, input bit ten, input bit rd, input int len,
                     input int nk, input string tag);
    int k = 0, wexp = 0, wi = 0, rd_n = 0, cyc = 0;
    bit ab = 0, got = 0, err = 0;
    logic [7:0] hdr0;
    for (int i = 0; i < 32; i++) wdat[i] = 8'($urandom);
    // expected request list
    e_n = 0;
    hdr0 = ten ? {5'b11110, a[9:8], 1'b0} : {a[6:0], rd};
    ex_add(K_START, 8'h00, 1'b0);
    ex_add(K_TX, hdr0, 1'b0); k++; if (k == nk) ab = 1;
    if (ten && !ab) begin
      ex_add(K_TX, a[7:0], 1'b0); k++; if (k == nk) ab = 1;
      if (rd && !ab) begin
        ex_add(K_RS, 8'h00, 1'b0);
        ex_add(K_TX, {5'b11110, a[9:8], 1'b1}, 1'b0); k++; if (k == nk) ab = 1;
      end
    end
    for (int i = 0; i < len && !ab; i++) begin
      if (rd) ex_add(K_RX, 8'h00, (i == len - 1));
      else begin
        ex_add(K_TX, wdat[i], 1'b0); wexp++; k++; if (k == nk) ab = 1;
      end
    end
    ex_add(K_STOP, 8'h00, 1'b0);

    log_n = 0; tx_k = 0; rx_k = 0; nack_at = nk;
    @(negedge clk);
    chk(cmd_ready, "R1", "ready while idle", int'(cmd_ready), 1);
    cmd_addr = a; cmd_ten = ten; cmd_read = rd; cmd_len = LW'(len); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R1", "ready drops after accept", int'(cmd_ready), 0);
    while (!got && cyc < 3000) begin
      @(negedge clk); cyc++;
      if (wr_valid) begin wr_valid = 1'b0; wi++; end
      if (wr_ready && ($urandom % 2 == 1)) begin wr_valid = 1'b1; wr_data = wdat[wi]; end
      rd_ready = ($urandom % 2 == 1);
      if (rd_valid && rd_ready) begin
        if (rd_n < 32) rd_got[rd_n] = rd_data;
        rd_n++;
      end
      if (txn_done) begin got = 1; err = txn_err; end
    end
    rd_ready = 1'b0; wr_valid = 1'b0;
    chk(got, "R2", "transaction completes", int'(got), 1);
    @(negedge clk);
    chk(!txn_done, "R2", "done is a single pulse", int'(txn_done), 0);
    chk(err == ab, ab ? "R8" : "R11", "error flag", int'(err), int'(ab));
    chk(log_n == e_n, tag, "request count", log_n, e_n);
    for (int i = 0; i < e_n && i < log_n; i++) begin
      chk(log_op[i] == e_op[i], tag, "request op", int'(log_op[i]), int'(e_op[i]));
      if (e_op[i] == K_TX)
        chk(log_b[i] == e_b[i], tag, "transmit byte", int'(log_b[i]), int'(e_b[i]));
      if (e_op[i] == K_RX)
        chk(log_nk[i] == e_nk[i], "R7", "ack/nack choice", int'(log_nk[i]), int'(e_nk[i]));
    end
    if (!rd) chk(wi == wexp, "R6", "write bytes taken", wi, wexp);
    else begin
      chk(rd_n == (ab ? 0 : len), "R7", "read bytes delivered", rd_n, ab ? 0 : len);
      for (int i = 0; i < rd_n && i < 32; i++)
        chk(rd_got[i] == gen_rx[i], "R7", "read byte order", int'(rd_got[i]), int'(gen_rx[i]));
    end
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(cmd_ready && !eng_req_valid && !wr_ready && !rd_valid && !txn_done,
        "R1", "reset state", int'({cmd_ready, eng_req_valid, wr_ready, rd_valid, txn_done}), 16);
    rst = 1'b0;
    // directed corner cases
    run(10'h05A, 0, 0, 3, 0, "R3");
    run(10'h023, 0, 1, 2, 0, "R3");
    run(10'h2C5, 1, 0, 2, 0, "R4");
    run(10'h3A7, 1, 1, 4, 0, "R5");
    run(10'h011, 0, 0, 0, 0, "R9");
    run(10'h155, 1, 1, 0, 0, "R9");
    run(10'h044, 0, 0, 3, 1, "R8");
    run(10'h1F0, 1, 1, 2, 2, "R8");
    run(10'h30F, 1, 1, 2, 3, "R8");
    run(10'h066, 0, 0, 4, 3, "R8");
    run(10'h07F, 0, 1, 1, 0, "R7");
    run(10'h000, 0, 0, 15, 0, "R6");
    run(10'h3FF, 1, 1, 15, 0, "R5");
    // random mix
    for (int t = 0; t < 30; t++) begin
      logic [9:0] a;
      bit ten, rd;
      int len, nk;
      a = 10'($urandom); ten = 1'($urandom); rd = 1'($urandom);
      len = $urandom % 7;
      nk = ($urandom % 4 == 0) ? 1 + ($urandom % 3) : 0;
      run(a, ten, rd, len, nk, (nk != 0) ? "R8" : (rd ? "R7" : "R6"));
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule